// File: doc/BRIEF.md
# Interrupt Aggregator with Message/Legacy Selection

The block gathers interrupt sources on the application side of an endpoint and turns them into link-level interrupt requests. A bank of mailbox status bits, each set by its own pulse and cleared by software writing a one, and a single application interrupt input are each gated by a private enable bit. The gated terms are OR-ed into one pending condition.

Two configuration control bits decide how the pending condition leaves the block. When the message-interrupt enable is set, a rising pending condition yields a single-cycle message request. When message interrupts are off and the legacy-disable bit is clear, the pending level is held in a set/clear flop that drives a virtual legacy wire. Each rise of that flop issues one assert-message request and each fall issues one deassert-message request. Software changes mode by turning the new mode on before turning the old one off. The block therefore lets message mode win while both are on, drops the legacy level cleanly when legacy is turned off, and re-signals a still-pending interrupt in whichever mode takes over.

All request outputs are single-cycle strobes with no back-pressure. The downstream message former must accept a strobe in the cycle it appears. The register write port is a plain strobe as well.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status register, the enable register, `msi_req`, `inta_level`, `inta_assert_req` and `inta_deassert_req` are all 0.
- R2: A 1 on `mbox_set[i]` sets status bit i at the next edge. A write to address 0 clears every status bit whose `wr_data` bit is 1 and leaves the other bits alone. A set pulse and a clearing write to the same bit in the same cycle leave the bit set.
- R3: A write to address 1 loads the enable register. Bits [NUM_MBOX-1:0] enable the mailbox bits and bit NUM_MBOX enables `app_irq`. Writes to any other address leave the enable register unchanged.
- R4: The pending condition is the OR of every status bit AND its enable, together with `app_irq` AND its enable. A source whose enable is 0 causes no request.
- R5: With `cfg_msi_enable`=1, a rise of the pending condition gives exactly one `msi_req` pulse, one cycle wide. No further pulse is given until pending has fallen and risen again.
- R6: With `cfg_msi_enable`=0 and `cfg_intx_disable`=0, a rise of pending sets `inta_level` and strobes `inta_assert_req` once in the same cycle. A fall of pending clears `inta_level` and strobes `inta_deassert_req` once.
- R7: While `cfg_intx_disable`=1 or `cfg_msi_enable`=1, no `inta_assert_req` is issued. If `inta_level` is 1 when legacy signalling becomes disallowed, `inta_level` clears and one `inta_deassert_req` is issued.
- R8: With both modes enabled (`cfg_msi_enable`=1, `cfg_intx_disable`=0), a rise of pending yields `msi_req` and no legacy assert.
- R9: An interrupt that stays pending across a mode switch is signalled in the new mode. Going from legacy to message gives one `msi_req` together with the legacy deassert. Going from message to legacy gives one `inta_assert_req`.
- R10: A request strobe appears one clock after the pending condition changes. An `app_irq` rise is therefore seen one edge later, and a `mbox_set` pulse on an enabled bit is seen two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_intx_disable | input | 1 | Legacy interrupt disable control bit |
| cfg_msi_enable | input | 1 | Message interrupt enable control bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 status, 1 enable) |
| wr_data | input | DATA_W | Register write data |
| mbox_set | input | NUM_MBOX | Per-bit mailbox status set pulses |
| app_irq | input | 1 | Application interrupt level |
| status_o | output | NUM_MBOX | Mailbox status register |
| enable_o | output | NUM_MBOX+1 | Enable register |
| msi_req | output | 1 | Single-cycle message interrupt request |
| inta_level | output | 1 | Virtual legacy interrupt level |
| inta_assert_req | output | 1 | Strobe: send legacy assert message |
| inta_deassert_req | output | 1 | Strobe: send legacy deassert message |

## Verification
The bench builds the block with NUM_MBOX=8, DATA_W=16 and ADDR_W=2. The enable word then sits inside the write data with spare upper bits, so the bench can show that those bits are ignored. The two-bit address also reaches two unused addresses, on which writes must leave the enable register alone. Eight mailbox bits give room for multi-bit set and clear patterns, and for a set-versus-clear collision on one bit while other bits stay set.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_MSI    = 2'd2
  } sig_mode_e;

  localparam int unsigned STATUS_ADDR = 0;
  localparam int unsigned ENABLE_ADDR = 1;

  // Message interrupts win when both controls allow signalling.
  function automatic sig_mode_e pick_mode(input logic intx_dis, input logic msi_en);
    if (msi_en)        return MODE_MSI;
    else if (!intx_dis) return MODE_LEGACY;
    else               return MODE_NONE;
  endfunction

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NUM_MBOX-1:0] mbox_set,
  output logic [NUM_MBOX-1:0] status_q,
  output logic [NUM_MBOX:0]   enable_q
);
  localparam int unsigned EN_W = NUM_MBOX + 1;

  logic                status_wr;
  logic                enable_wr;
  logic [NUM_MBOX-1:0] st;

  assign status_wr = wr_en && (wr_addr == ADDR_W'(STATUS_ADDR));
  assign enable_wr = wr_en && (wr_addr == ADDR_W'(ENABLE_ADDR));

  // One flop per mailbox bit: a set pulse beats a clearing write.
  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_status
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       st[i] <= 1'b0;
      else if (mbox_set[i])             st[i] <= 1'b1;
      else if (status_wr && wr_data[i]) st[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable_q <= '0;
    else if (enable_wr) enable_q <= wr_data[EN_W-1:0];
  end

  assign status_q = st;

  if (DATA_W > EN_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^wr_data[DATA_W-1:EN_W];
  end

endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine #(
  parameter int unsigned NUM_MBOX = 8
) (
  input  logic [NUM_MBOX-1:0] status,
  input  logic [NUM_MBOX:0]   enable,
  input  logic                app_irq,
  output logic                pending
);
  logic [NUM_MBOX:0] term;

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_term
    assign term[i] = status[i] & enable[i];
  end
  assign term[NUM_MBOX] = app_irq & enable[NUM_MBOX];

  assign pending = |term;

endmodule

// File: rtl/irq_agg_msi.sv
module irq_agg_msi (
  input  logic clk,
  input  logic rst_n,
  input  logic msi_mode,
  input  logic pending,
  output logic msi_req
);
  logic sent_q;
  logic fire;

  // One request per pending episode; the episode ends when pending drops.
  assign fire = msi_mode && pending && !sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q  <= 1'b0;
      msi_req <= 1'b0;
    end else begin
      msi_req <= fire;
      if (fire)         sent_q <= 1'b1;
      else if (!pending) sent_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_agg_intx.sv
module irq_agg_intx (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy_ok,
  input  logic pending,
  output logic inta_level,
  output logic assert_req,
  output logic deassert_req
);
  logic set_c;
  logic clr_c;

  assign set_c = legacy_ok && pending && !inta_level;
  assign clr_c = inta_level && (!pending || !legacy_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_level   <= 1'b0;
      assert_req   <= 1'b0;
      deassert_req <= 1'b0;
    end else begin
      assert_req   <= set_c;
      deassert_req <= clr_c;
      if (set_c)      inta_level <= 1'b1;
      else if (clr_c) inta_level <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_intx_disable,
  input  logic                cfg_msi_enable,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NUM_MBOX-1:0] mbox_set,
  input  logic                app_irq,
  output logic [NUM_MBOX-1:0] status_o,
  output logic [NUM_MBOX:0]   enable_o,
  output logic                msi_req,
  output logic                inta_level,
  output logic                inta_assert_req,
  output logic                inta_deassert_req
);
  sig_mode_e mode;
  logic      pending;

  assign mode = pick_mode(cfg_intx_disable, cfg_msi_enable);

  irq_agg_regs #(
    .NUM_MBOX(NUM_MBOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mbox_set (mbox_set),
    .status_q (status_o),
    .enable_q (enable_o)
  );

  irq_agg_combine #(.NUM_MBOX(NUM_MBOX)) u_combine (
    .status  (status_o),
    .enable  (enable_o),
    .app_irq (app_irq),
    .pending (pending)
  );

  irq_agg_msi u_msi (
    .clk      (clk),
    .rst_n    (rst_n),
    .msi_mode (mode == MODE_MSI),
    .pending  (pending),
    .msi_req  (msi_req)
  );

  irq_agg_intx u_intx (
    .clk          (clk),
    .rst_n        (rst_n),
    .legacy_ok    (mode == MODE_LEGACY),
    .pending      (pending),
    .inta_level   (inta_level),
    .assert_req   (inta_assert_req),
    .deassert_req (inta_deassert_req)
  );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_intx_disable,
  input logic                cfg_msi_enable,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [NUM_MBOX-1:0] mbox_set,
  input logic [NUM_MBOX-1:0] status_o,
  input logic [NUM_MBOX:0]   enable_o,
  input logic                msi_req,
  input logic                inta_level,
  input logic                inta_assert_req,
  input logic                inta_deassert_req
);
  logic [NUM_MBOX-1:0] clr_mask;
  assign clr_mask = wr_data[NUM_MBOX-1:0] & ~mbox_set;

  // R2
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mbox_set) |=> ((status_o & $past(mbox_set)) == $past(mbox_set)));

  // R2
  status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(STATUS_ADDR) && clr_mask != '0)
      |=> ((status_o & $past(clr_mask)) == '0));

  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_W'(ENABLE_ADDR)) |=> $stable(enable_o));

  // R5
  msi_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);

  // R5
  msi_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(cfg_msi_enable));

  // R6
  inta_assert_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_assert_req |-> (inta_level && !$past(inta_level)));

  // R6
  inta_deassert_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_deassert_req |-> (!inta_level && $past(inta_level)));

  // R6
  inta_level_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_level != $past(inta_level)) |-> (inta_assert_req || inta_deassert_req));

  // R7
  inta_assert_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_assert_req |-> ($past(!cfg_intx_disable) && $past(!cfg_msi_enable)));

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_MBOX(NUM_MBOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int unsigned NUM_MBOX = 8;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_intx_disable = 1'b1;
  logic                cfg_msi_enable = 1'b0;
  logic                wr_en = 1'b0;
  logic [ADDR_W-1:0]   wr_addr = '0;
  logic [DATA_W-1:0]   wr_data = '0;
  logic [NUM_MBOX-1:0] mbox_set = '0;
  logic                app_irq = 1'b0;
  logic [NUM_MBOX-1:0] status_o;
  logic [NUM_MBOX:0]   enable_o;
  logic                msi_req;
  logic                inta_level;
  logic                inta_assert_req;
  logic                inta_deassert_req;

  int vectors = 0;
  int miscompares = 0;
  int msi_cnt = 0, as_cnt = 0, de_cnt = 0, wide_cnt = 0;
  logic msi_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator #(.NUM_MBOX(NUM_MBOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .cfg_intx_disable(cfg_intx_disable),
    .cfg_msi_enable(cfg_msi_enable), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mbox_set(mbox_set), .app_irq(app_irq),
    .status_o(status_o), .enable_o(enable_o), .msi_req(msi_req),
    .inta_level(inta_level), .inta_assert_req(inta_assert_req),
    .inta_deassert_req(inta_deassert_req)
  );

  // Pulse counters sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (msi_req) msi_cnt++;
      if (msi_req && msi_prev) wide_cnt++;
      if (inta_assert_req) as_cnt++;
      if (inta_deassert_req) de_cnt++;
      msi_prev <= msi_req;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_set(input logic [NUM_MBOX-1:0] m);
    mbox_set = m; tick(); mbox_set = '0;
  endtask

  task automatic t_reset;
    check("R1 status", 32'(status_o), 0);
    check("R1 enable", 32'(enable_o), 0);
    check("R1 requests", {29'd0, msi_req, inta_assert_req, inta_deassert_req}, 0);
    check("R1 level", 32'(inta_level), 0);
  endtask

  task automatic t_regs;
    pulse_set(8'hA5);
    check("R2 set pulses", 32'(status_o), 32'hA5);
    wr(0, 16'h0005);
    check("R2 w1c partial", 32'(status_o), 32'hA0);
    mbox_set = 8'h80; wr_en = 1'b1; wr_addr = 0; wr_data = 16'h0080;
    tick();
    mbox_set = '0; wr_en = 1'b0; wr_data = '0;
    check("R2 set beats clear", 32'(status_o), 32'hA0);
    wr(1, 16'h01FF);
    check("R3 enable load", 32'(enable_o), 32'h1FF);
    wr(2, 16'h0000);
    check("R3 addr2 ignored", 32'(enable_o), 32'h1FF);
    wr(3, 16'h0000);
    check("R3 addr3 ignored", 32'(enable_o), 32'h1FF);
    wr(1, 16'hFE00);
    check("R3 upper bits dropped", 32'(enable_o), 32'h000);
    wr(0, 16'h00FF);
    check("R2 clear all", 32'(status_o), 0);
    check("R7 no request with both modes off", 32'(msi_cnt + as_cnt), 0);
  endtask

  task automatic t_mask;
    int m0;
    cfg_msi_enable = 1'b1; cfg_intx_disable = 1'b1;
    tick();
    m0 = msi_cnt;
    pulse_set(8'h08);
    app_irq = 1'b1;
    tick(4);
    check("R4 masked sources silent", 32'(msi_cnt - m0), 0);
    app_irq = 1'b0;
    wr(1, 16'h0008);
    tick();
    check("R10 request one edge after enable", 32'(msi_req), 1);
    tick();
    check("R5 pulse one cycle", 32'(msi_req), 0);
    wr(0, 16'h0008);
    tick(2);
    check("R4 one request once unmasked", 32'(msi_cnt - m0), 1);
  endtask

  task automatic t_msi;
    int m0, a0;
    wr(1, 16'h01FF);
    tick();
    m0 = msi_cnt; a0 = as_cnt;
    app_irq = 1'b1;
    tick();
    check("R10 app_irq latency", 32'(msi_req), 1);
    tick();
    check("R5 single cycle", 32'(msi_req), 0);
    pulse_set(8'h02);
    tick(5);
    check("R5 no repeat while pending", 32'(msi_cnt - m0), 1);
    app_irq = 1'b0;
    wr(0, 16'h0002);
    tick(2);
    pulse_set(8'h40);
    check("R10 mailbox not yet", 32'(msi_req), 0);
    tick();
    check("R10 mailbox second edge", 32'(msi_req), 1);
    wr(0, 16'h0040);
    tick(2);
    check("R5 new episode new pulse", 32'(msi_cnt - m0), 2);
    check("R5 no legacy in msi mode", 32'(as_cnt - a0), 0);
  endtask

  task automatic t_legacy;
    int a0, d0, m0;
    cfg_msi_enable = 1'b0; cfg_intx_disable = 1'b0;
    tick();
    a0 = as_cnt; d0 = de_cnt; m0 = msi_cnt;
    app_irq = 1'b1;
    tick();
    check("R6 assert strobe with level", {30'd0, inta_level, inta_assert_req}, 32'h3);
    tick(4);
    check("R6 one assert", 32'(as_cnt - a0), 1);
    app_irq = 1'b0;
    tick();
    check("R6 deassert strobe, level low", {30'd0, inta_level, inta_deassert_req}, 32'h1);
    tick(3);
    check("R6 one deassert", 32'(de_cnt - d0), 1);
    check("R6 no msi in legacy", 32'(msi_cnt - m0), 0);
  endtask

  task automatic t_disable;
    int a0, d0;
    a0 = as_cnt; d0 = de_cnt;
    app_irq = 1'b1;
    tick(2);
    cfg_intx_disable = 1'b1;
    tick();
    check("R7 forced deassert", {30'd0, inta_level, inta_deassert_req}, 32'h1);
    tick(2);
    app_irq = 1'b0; tick();
    app_irq = 1'b1; tick(3);
    check("R7 no assert while disabled", 32'(as_cnt - a0), 1);
    check("R7 level stays low", 32'(inta_level), 0);
    check("R7 one deassert", 32'(de_cnt - d0), 1);
    app_irq = 1'b0; cfg_intx_disable = 1'b0;
    tick(2);
  endtask

  task automatic t_both;
    int a0, m0;
    cfg_msi_enable = 1'b1; cfg_intx_disable = 1'b0;
    tick();
    a0 = as_cnt; m0 = msi_cnt;
    app_irq = 1'b1;
    tick(3);
    check("R8 msi wins", 32'(msi_cnt - m0), 1);
    check("R8 no legacy assert", {31'd0, inta_level} + 32'(as_cnt - a0), 0);
    app_irq = 1'b0;
    tick(2);
  endtask

  task automatic t_switch;
    int a0, d0, m0;
    cfg_msi_enable = 1'b0; cfg_intx_disable = 1'b0;
    tick();
    a0 = as_cnt; d0 = de_cnt; m0 = msi_cnt;
    app_irq = 1'b1;
    tick(2);
    cfg_msi_enable = 1'b1;
    tick();
    check("R9 legacy->msi handoff", {30'd0, msi_req, inta_deassert_req}, 32'h3);
    cfg_intx_disable = 1'b1;
    tick(3);
    check("R9 one msi per handoff", 32'(msi_cnt - m0), 1);
    cfg_intx_disable = 1'b0;
    tick(3);
    check("R8 msi still wins", 32'(inta_level), 0);
    cfg_msi_enable = 1'b0;
    tick();
    check("R9 msi->legacy handoff", {30'd0, inta_level, inta_assert_req}, 32'h3);
    app_irq = 1'b0;
    tick();
    check("R6 deassert after switch", 32'(inta_deassert_req), 1);
    tick(2);
    check("R9 message totals", 32'((as_cnt - a0) * 16 + (de_cnt - d0)), 32'h22);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_mask();
    t_msi();
    t_legacy();
    t_disable();
    t_both();
    t_switch();
    check("R5 no wide msi pulse", 32'(wide_cnt), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule